// File: doc/BRIEF.md
# Dual Baseband Frequency Shifter

This block moves complex baseband samples up or down in frequency with a numerically controlled oscillator. One wideband radio front end can then serve several narrow channels without the analog synthesizer being retuned. There are two separate shifters: one on the receive stream and one on the transmit stream. Each has its own oscillator, so a node can receive on one channel and transmit on another at the same time. An example is relaying traffic from one channel to a channel two steps higher. With a 5 MHz channel spacing that is a 10 MHz offset, which is 0x33333333 at 50 MS/s.

Each shifter takes signed 16-bit I/Q samples qualified by a valid strobe. It keeps a 32-bit phase accumulator that advances by a programmable increment on every accepted sample. The increment is the frequency offset divided by the sample rate, times 2^32, in two's complement, so negative shifts are possible. The top 10 bits of the phase select a sine/cosine value from a quarter-wave table. The sample is rotated by that angle in a three-stage pipelined complex multiply, then rounded and saturated back to 16 bits. A new increment goes through a holding register and reaches the accumulator only at a sample boundary. A retune therefore takes effect on the next samples, with no relock.

Top module: `ncosh_dual_shifter`

## Requirements
- R1: For a sample (I, Q) taken at phase word P, let a = P[31:22], c = round(32767*cos(2*pi*a/1024)) and s = round(32767*sin(2*pi*a/1024)). The outputs are I' = (I*c - Q*s + 16384) >>> 15 and Q' = (I*s + Q*c + 16384) >>> 15. A positive increment turns the signal counter-clockwise, and a negative (two's complement) increment turns it clockwise.
- R2: Each sample accepted with in_valid high at a rising edge produces exactly one output. Its out_valid is high after the fifth rising edge counting that one, in the same order, and out_valid is low in every other cycle.
- R3: The phase word starts at 0 after reset. It advances modulo 2^32 by the active increment once per accepted sample and never in cycles without a sample, so sample n+1 uses the phase of sample n plus the increment.
- R4: A one-cycle inc_wr strobe stores inc_val in a holding register. The first accepted sample after the write still uses its already computed phase, and from then on every step uses the new value. A later write before any sample replaces the held value.
- R5: A one-cycle phase_clr strobe makes the next accepted sample use phase 0. Following samples continue from 0 by the increment.
- R6: A sample whose phase word is exactly 0 leaves the block unchanged, bit for bit, including full-scale values. A zero increment after a phase clear therefore passes the stream through.
- R7: Results above 32767 or below -32768 are clamped to those limits.
- R8: The receive and transmit shifters share no state. Increments, clears and samples on one path never change the other path's outputs, even when both are active in the same cycles.
- R9: While rst is high and in the cycle after, out_valid is low and the output data are zero on both paths. The increment is 0.
- R10: While out_valid is low, the output data hold the last value produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in_valid | input | 1 | Receive sample strobe |
| rx_in_i | input | 16 | Receive in-phase sample, signed |
| rx_in_q | input | 16 | Receive quadrature sample, signed |
| rx_inc_wr | input | 1 | Receive increment write strobe |
| rx_inc_val | input | 32 | Receive phase increment, two's complement |
| rx_phase_clr | input | 1 | Receive phase clear strobe |
| rx_out_valid | output | 1 | Receive result strobe |
| rx_out_i | output | 16 | Receive shifted in-phase sample |
| rx_out_q | output | 16 | Receive shifted quadrature sample |
| tx_in_valid | input | 1 | Transmit sample strobe |
| tx_in_i | input | 16 | Transmit in-phase sample, signed |
| tx_in_q | input | 16 | Transmit quadrature sample, signed |
| tx_inc_wr | input | 1 | Transmit increment write strobe |
| tx_inc_val | input | 32 | Transmit phase increment, two's complement |
| tx_phase_clr | input | 1 | Transmit phase clear strobe |
| tx_out_valid | output | 1 | Transmit result strobe |
| tx_out_i | output | 16 | Transmit shifted in-phase sample |
| tx_out_q | output | 16 | Transmit shifted quadrature sample |

## Verification
The rotation is driven with several increments, and each one separates a different kind of fault:
- Quarter-turn increments, both positive and negative, give exact angles. They expose swapped sine and cosine terms, a wrong quadrant fold and a wrong direction of rotation.
- An eighth-turn increment with full-scale inputs drives the result into both saturation limits.
- An increment for a 10 MHz offset lands on table entries between the quarter points. It checks the table values themselves.

The ordering cases are tested directly:
- Samples with idle gaps between them separate per-sample stepping from per-clock stepping.
- Writes and clears in the middle of a stream test the sample-boundary handover.
- Receive and transmit samples arriving in the same cycles with different increments would reveal any shared state.

// File: rtl/ncosh_pkg.sv
package ncosh_pkg;
  localparam int SAMPLE_W = 16;
  localparam int PHASE_W  = 32;
  localparam int ADDR_W   = 10;
  localparam int PIPE_LAT = 5;

  // Quarter-wave entry: round(amp * sin(pi/2 * idx / 2^qbits))
  function automatic int quarter_entry(input int idx, input int qbits, input int amp);
    real ang;
    ang = 3.14159265358979323846 * 0.5 * real'(idx) / real'(1 << qbits);
    return int'($floor(real'(amp) * $sin(ang) + 0.5));
  endfunction
endpackage

// File: rtl/ncosh_phase_acc.sv
module ncosh_phase_acc #(
  parameter int PW = ncosh_pkg::PHASE_W,
  parameter int SW = ncosh_pkg::SAMPLE_W,
  parameter int AW = ncosh_pkg::ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inc_wr,
  input  logic [PW-1:0]        inc_val,
  input  logic                 phase_clr,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic                 s0_valid,
  output logic [AW-1:0]        s0_addr,
  output logic signed [SW-1:0] s0_i,
  output logic signed [SW-1:0] s0_q,
  output logic                 s0_zero
);
  logic [PW-1:0] acc_q, inc_act_q, inc_hold_q;
  logic          inc_pend_q, clr_pend_q;
  logic [PW-1:0] ph_use, step;

  always_comb begin
    ph_use = clr_pend_q ? '0 : acc_q;
    step   = inc_pend_q ? inc_hold_q : inc_act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      inc_act_q  <= '0;
      inc_hold_q <= '0;
      inc_pend_q <= 1'b0;
      clr_pend_q <= 1'b0;
      s0_valid   <= 1'b0;
      s0_addr    <= '0;
      s0_i       <= '0;
      s0_q       <= '0;
      s0_zero    <= 1'b0;
    end else begin
      if (inc_wr) begin
        inc_hold_q <= inc_val;
        inc_pend_q <= 1'b1;
      end else if (in_valid) begin
        inc_pend_q <= 1'b0;
      end
      if (phase_clr)     clr_pend_q <= 1'b1;
      else if (in_valid) clr_pend_q <= 1'b0;
      s0_valid <= in_valid;
      if (in_valid) begin
        acc_q     <= ph_use + step;
        inc_act_q <= step;
        s0_addr   <= ph_use[PW-1 -: AW];
        s0_i      <= in_i;
        s0_q      <= in_q;
        s0_zero   <= (ph_use == '0);
      end
    end
  end
endmodule

// File: rtl/ncosh_sincos_rom.sv
module ncosh_sincos_rom #(
  parameter int AW = ncosh_pkg::ADDR_W,
  parameter int SW = ncosh_pkg::SAMPLE_W
) (
  input  logic                 clk,
  input  logic [AW-1:0]        addr,
  output logic signed [SW-1:0] sin_o,
  output logic signed [SW-1:0] cos_o
);
  localparam int QW     = AW - 2;
  localparam int QDEPTH = (1 << QW) + 1;
  localparam int AMP    = (1 << (SW - 1)) - 1;
  localparam logic [QW:0] QFULL = (QW+1)'(1) << QW;

  logic signed [SW-1:0] rom [QDEPTH];

  for (genvar k = 0; k < QDEPTH; k++) begin : g_tab
    assign rom[k] = SW'(ncosh_pkg::quarter_entry(k, QW, AMP));
  end

  logic [1:0]  quad;
  logic [QW:0] idx_fwd, idx_rev, sin_sel, cos_sel;
  logic        sin_neg, cos_neg;

  always_comb begin
    quad    = addr[AW-1 -: 2];
    idx_fwd = {1'b0, addr[QW-1:0]};
    idx_rev = QFULL - idx_fwd;
    unique case (quad)
      2'd0: begin sin_sel = idx_fwd; sin_neg = 1'b0; cos_sel = idx_rev; cos_neg = 1'b0; end
      2'd1: begin sin_sel = idx_rev; sin_neg = 1'b0; cos_sel = idx_fwd; cos_neg = 1'b1; end
      2'd2: begin sin_sel = idx_fwd; sin_neg = 1'b1; cos_sel = idx_rev; cos_neg = 1'b1; end
      default: begin sin_sel = idx_rev; sin_neg = 1'b1; cos_sel = idx_fwd; cos_neg = 1'b0; end
    endcase
  end

  logic signed [SW-1:0] sin_mag_q, cos_mag_q;
  logic                 sin_neg_q, cos_neg_q;

  always_ff @(posedge clk) begin
    sin_mag_q <= rom[sin_sel];
    cos_mag_q <= rom[cos_sel];
    sin_neg_q <= sin_neg;
    cos_neg_q <= cos_neg;
  end

  always_comb begin
    sin_o = sin_neg_q ? -sin_mag_q : sin_mag_q;
    cos_o = cos_neg_q ? -cos_mag_q : cos_mag_q;
  end
endmodule

// File: rtl/ncosh_cmul.sv
module ncosh_cmul #(
  parameter int SW = ncosh_pkg::SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 bypass,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  input  logic signed [SW-1:0] cos_v,
  input  logic signed [SW-1:0] sin_v,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q
);
  localparam int PRW  = 2 * SW;
  localparam int SUMW = PRW + 1;
  localparam int MAXI = (1 << (SW - 1)) - 1;
  localparam int MINI = -(1 << (SW - 1));
  localparam logic signed [SUMW-1:0] HALF = SUMW'(1) << (SW - 2);

  function automatic logic signed [SW-1:0] rnd_sat(input logic signed [SUMW-1:0] v);
    logic signed [SUMW-1:0] r;
    r = (v + HALF) >>> (SW - 1);
    if (r > SUMW'(MAXI))      return MAXI[SW-1:0];
    else if (r < SUMW'(MINI)) return MINI[SW-1:0];
    else                      return r[SW-1:0];
  endfunction

  // stage 1: products
  logic                  v1, b1;
  logic signed [SW-1:0]  r1_i, r1_q;
  logic signed [PRW-1:0] p_ic, p_qs, p_is, p_qc;
  // stage 2: sums
  logic                  v2, b2;
  logic signed [SW-1:0]  r2_i, r2_q;
  logic signed [SUMW-1:0] s_i, s_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; b1 <= 1'b0; r1_i <= '0; r1_q <= '0;
      p_ic <= '0; p_qs <= '0; p_is <= '0; p_qc <= '0;
      v2 <= 1'b0; b2 <= 1'b0; r2_i <= '0; r2_q <= '0;
      s_i <= '0; s_q <= '0;
      out_valid <= 1'b0; out_i <= '0; out_q <= '0;
    end else begin
      v1   <= in_valid;
      b1   <= bypass;
      r1_i <= in_i;
      r1_q <= in_q;
      p_ic <= in_i * cos_v;
      p_qs <= in_q * sin_v;
      p_is <= in_i * sin_v;
      p_qc <= in_q * cos_v;

      v2   <= v1;
      b2   <= b1;
      r2_i <= r1_i;
      r2_q <= r1_q;
      s_i  <= SUMW'(p_ic) - SUMW'(p_qs);
      s_q  <= SUMW'(p_is) + SUMW'(p_qc);

      out_valid <= v2;
      if (v2) begin
        out_i <= b2 ? r2_i : rnd_sat(s_i);
        out_q <= b2 ? r2_q : rnd_sat(s_q);
      end
    end
  end
endmodule

// File: rtl/ncosh_shifter.sv
module ncosh_shifter #(
  parameter int PW = ncosh_pkg::PHASE_W,
  parameter int SW = ncosh_pkg::SAMPLE_W,
  parameter int AW = ncosh_pkg::ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  input  logic                 inc_wr,
  input  logic [PW-1:0]        inc_val,
  input  logic                 phase_clr,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q
);
  logic                 s0_valid, s0_zero;
  logic [AW-1:0]        s0_addr;
  logic signed [SW-1:0] s0_i, s0_q;

  ncosh_phase_acc #(.PW(PW), .SW(SW), .AW(AW)) u_acc (
    .clk(clk), .rst(rst), .inc_wr(inc_wr), .inc_val(inc_val),
    .phase_clr(phase_clr), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .s0_valid(s0_valid), .s0_addr(s0_addr), .s0_i(s0_i), .s0_q(s0_q),
    .s0_zero(s0_zero)
  );

  logic signed [SW-1:0] sin_v, cos_v;

  ncosh_sincos_rom #(.AW(AW), .SW(SW)) u_rom (
    .clk(clk), .addr(s0_addr), .sin_o(sin_v), .cos_o(cos_v)
  );

  // align the sample with the table read latency
  logic                 s1_valid, s1_zero;
  logic signed [SW-1:0] s1_i, s1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_zero  <= 1'b0;
      s1_i     <= '0;
      s1_q     <= '0;
    end else begin
      s1_valid <= s0_valid;
      s1_zero  <= s0_zero;
      s1_i     <= s0_i;
      s1_q     <= s0_q;
    end
  end

  ncosh_cmul #(.SW(SW)) u_mul (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .bypass(s1_zero),
    .in_i(s1_i), .in_q(s1_q), .cos_v(cos_v), .sin_v(sin_v),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );
endmodule

// File: rtl/ncosh_dual_shifter.sv
module ncosh_dual_shifter #(
  parameter int PW = ncosh_pkg::PHASE_W,
  parameter int SW = ncosh_pkg::SAMPLE_W,
  parameter int AW = ncosh_pkg::ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_in_valid,
  input  logic signed [SW-1:0] rx_in_i,
  input  logic signed [SW-1:0] rx_in_q,
  input  logic                 rx_inc_wr,
  input  logic [PW-1:0]        rx_inc_val,
  input  logic                 rx_phase_clr,
  output logic                 rx_out_valid,
  output logic signed [SW-1:0] rx_out_i,
  output logic signed [SW-1:0] rx_out_q,
  input  logic                 tx_in_valid,
  input  logic signed [SW-1:0] tx_in_i,
  input  logic signed [SW-1:0] tx_in_q,
  input  logic                 tx_inc_wr,
  input  logic [PW-1:0]        tx_inc_val,
  input  logic                 tx_phase_clr,
  output logic                 tx_out_valid,
  output logic signed [SW-1:0] tx_out_i,
  output logic signed [SW-1:0] tx_out_q
);
  ncosh_shifter #(.PW(PW), .SW(SW), .AW(AW)) u_rx (
    .clk(clk), .rst(rst), .in_valid(rx_in_valid), .in_i(rx_in_i), .in_q(rx_in_q),
    .inc_wr(rx_inc_wr), .inc_val(rx_inc_val), .phase_clr(rx_phase_clr),
    .out_valid(rx_out_valid), .out_i(rx_out_i), .out_q(rx_out_q)
  );

  ncosh_shifter #(.PW(PW), .SW(SW), .AW(AW)) u_tx (
    .clk(clk), .rst(rst), .in_valid(tx_in_valid), .in_i(tx_in_i), .in_q(tx_in_q),
    .inc_wr(tx_inc_wr), .inc_val(tx_inc_val), .phase_clr(tx_phase_clr),
    .out_valid(tx_out_valid), .out_i(tx_out_i), .out_q(tx_out_q)
  );
endmodule

// File: rtl/ncosh_dual_shifter_chk.sv
module ncosh_dual_shifter_chk #(
  parameter int PW = ncosh_pkg::PHASE_W,
  parameter int SW = ncosh_pkg::SAMPLE_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_in_valid,
  input logic signed [SW-1:0] rx_in_i,
  input logic signed [SW-1:0] rx_in_q,
  input logic                 rx_inc_wr,
  input logic [PW-1:0]        rx_inc_val,
  input logic                 rx_out_valid,
  input logic signed [SW-1:0] rx_out_i,
  input logic signed [SW-1:0] rx_out_q,
  input logic                 tx_in_valid,
  input logic signed [SW-1:0] tx_in_i,
  input logic signed [SW-1:0] tx_in_q,
  input logic                 tx_inc_wr,
  input logic [PW-1:0]        tx_inc_val,
  input logic                 tx_out_valid,
  input logic signed [SW-1:0] tx_out_i,
  input logic signed [SW-1:0] tx_out_q
);
  logic [2:0] warm_q;
  logic       warm;
  logic       rx_untuned_q, tx_untuned_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q       <= '0;
      rx_untuned_q <= 1'b1;
      tx_untuned_q <= 1'b1;
    end else begin
      if (warm_q != 3'd5) warm_q <= warm_q + 3'd1;
      if (rx_inc_wr && rx_inc_val != '0) rx_untuned_q <= 1'b0;
      if (tx_inc_wr && tx_inc_val != '0) tx_untuned_q <= 1'b0;
    end
  end

  assign warm = (warm_q == 3'd5);

  // R2: one result per accepted sample, five edges later
  a_r2_rx_latency: assert property (@(posedge clk) disable iff (rst)
    warm |-> rx_out_valid == $past(rx_in_valid, 5));
  a_r2_tx_latency: assert property (@(posedge clk) disable iff (rst)
    warm |-> tx_out_valid == $past(tx_in_valid, 5));

  // R10: data hold while no result is flagged
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (warm && !rx_out_valid) |-> $stable(rx_out_i) && $stable(rx_out_q));
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (warm && !tx_out_valid) |-> $stable(tx_out_i) && $stable(tx_out_q));

  // R6: oscillator never moved from phase zero -> exact passthrough
  a_r6_rx_passthru: assert property (@(posedge clk) disable iff (rst)
    (warm && rx_out_valid && $past(rx_untuned_q, 5)) |->
      rx_out_i == $past(rx_in_i, 5) && rx_out_q == $past(rx_in_q, 5));
  a_r6_tx_passthru: assert property (@(posedge clk) disable iff (rst)
    (warm && tx_out_valid && $past(tx_untuned_q, 5)) |->
      tx_out_i == $past(tx_in_i, 5) && tx_out_q == $past(tx_in_q, 5));
endmodule

bind ncosh_dual_shifter ncosh_dual_shifter_chk u_chk (.*);

// File: tb/tb_ncosh_dual_shifter.sv
module tb_ncosh_dual_shifter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic               rx_in_valid = 0, rx_inc_wr = 0, rx_phase_clr = 0;
  logic signed [15:0] rx_in_i = 0, rx_in_q = 0;
  logic [31:0]        rx_inc_val = 0;
  logic               tx_in_valid = 0, tx_inc_wr = 0, tx_phase_clr = 0;
  logic signed [15:0] tx_in_i = 0, tx_in_q = 0;
  logic [31:0]        tx_inc_val = 0;
  logic               rx_out_valid, tx_out_valid;
  logic signed [15:0] rx_out_i, rx_out_q, tx_out_i, tx_out_q;

  ncosh_dual_shifter dut (.*);

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model, per path (0 rx, 1 tx)
  logic [31:0] m_acc [2], m_act [2], m_hold [2];
  bit          m_pend [2], m_clr [2];
  logic [31:0] q_exp [2][$];
  string       q_req [2][$];

  function automatic int rnd(input real x);
    return int'($floor(x + 0.5));
  endfunction

  function automatic logic [31:0] mix(input logic signed [15:0] i, input logic signed [15:0] q,
                                      input logic [31:0] ph);
    longint c, s, ti, tq;
    real ang;
    if (ph == 0) return {i, q};
    ang = 2.0 * 3.14159265358979323846 * real'(ph[31:22]) / 1024.0;
    c  = longint'(rnd(32767.0 * $cos(ang)));
    s  = longint'(rnd(32767.0 * $sin(ang)));
    ti = (longint'(i) * c - longint'(q) * s + 16384) >>> 15;
    tq = (longint'(i) * s + longint'(q) * c + 16384) >>> 15;
    if (ti > 32767) ti = 32767;
    if (ti < -32768) ti = -32768;
    if (tq > 32767) tq = 32767;
    if (tq < -32768) tq = -32768;
    return {ti[15:0], tq[15:0]};
  endfunction

  function automatic void model_sample(input int p, input logic signed [15:0] i,
                                       input logic signed [15:0] q, input string req);
    logic [31:0] ph, st;
    ph = m_clr[p] ? 32'd0 : m_acc[p];
    st = m_pend[p] ? m_hold[p] : m_act[p];
    q_exp[p].push_back(mix(i, q, ph));
    q_req[p].push_back(req);
    m_acc[p] = ph + st;
    m_act[p] = st;
    m_pend[p] = 0;
    m_clr[p] = 0;
  endfunction

  // ---------------- drivers (change inputs at falling edges)
  task automatic set_inc(input int p, input logic [31:0] v);
    @(negedge clk);
    if (p == 0) begin rx_inc_wr = 1; rx_inc_val = v; end
    else        begin tx_inc_wr = 1; tx_inc_val = v; end
    m_hold[p] = v; m_pend[p] = 1;
    @(negedge clk);
    rx_inc_wr = 0; tx_inc_wr = 0;
  endtask

  task automatic clr_phase(input int p);
    @(negedge clk);
    if (p == 0) rx_phase_clr = 1; else tx_phase_clr = 1;
    m_clr[p] = 1;
    @(negedge clk);
    rx_phase_clr = 0; tx_phase_clr = 0;
  endtask

  task automatic send(input int p, input logic signed [15:0] i,
                      input logic signed [15:0] q, input string req);
    @(negedge clk);
    if (p == 0) begin rx_in_valid = 1; rx_in_i = i; rx_in_q = q; tx_in_valid = 0; end
    else        begin tx_in_valid = 1; tx_in_i = i; tx_in_q = q; rx_in_valid = 0; end
    model_sample(p, i, q, req);
  endtask

  task automatic send_both(input logic signed [15:0] ri, input logic signed [15:0] rq,
                           input logic signed [15:0] ti, input logic signed [15:0] tq);
    @(negedge clk);
    rx_in_valid = 1; rx_in_i = ri; rx_in_q = rq;
    tx_in_valid = 1; tx_in_i = ti; tx_in_q = tq;
    model_sample(0, ri, rq, "R8");
    model_sample(1, ti, tq, "R8");
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_in_valid = 0; tx_in_valid = 0;
    end
  endtask

  // ---------------- output monitor
  logic [31:0] last_out [2];
  int          hold_viol = 0;
  bit          mon_en = 0;

  task automatic take(input int p, input logic v, input logic [31:0] got);
    logic [31:0] e;
    string r;
    if (v) begin
      if (q_exp[p].size() == 0) begin
        chk(0, "R2", "unexpected output", longint'(got), 0);
      end else begin
        e = q_exp[p].pop_front();
        r = q_req[p].pop_front();
        chk(got[31:16] == e[31:16], r, "I", longint'($signed(got[31:16])), longint'($signed(e[31:16])));
        chk(got[15:0] == e[15:0], r, "Q", longint'($signed(got[15:0])), longint'($signed(e[15:0])));
      end
      last_out[p] = got;
    end else if (got != last_out[p]) begin
      hold_viol++;
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      take(0, rx_out_valid, {rx_out_i, rx_out_q});
      take(1, tx_out_valid, {tx_out_i, tx_out_q});
    end
  end

  // ---------------- vector table: path, increment, I, Q, sample count
  typedef struct packed {
    logic               p;
    logic [31:0]        inc;
    logic signed [15:0] i;
    logic signed [15:0] q;
    logic [3:0]         n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 32'h0000_0000, 16'sd32767, -16'sd32768, 4'd3},  // zero phase passthrough
    '{1'b0, 32'h4000_0000, 16'sd10000, 16'sd3000,   4'd5},  // +quarter turns
    '{1'b0, 32'hC000_0000, 16'sd10000, 16'sd3000,   4'd5},  // -quarter turns
    '{1'b1, 32'h2000_0000, 16'sd32767, 16'sd32767,  4'd8},  // eighth turns, + clamp
    '{1'b0, 32'hE000_0000, -16'sd32768, -16'sd32768, 4'd4}, // -eighth turns, - clamp
    '{1'b1, 32'h3333_3333, 16'sd20000, -16'sd5000,  4'd6}   // 10 MHz at 50 MS/s
  };

  bit finished = 0;

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_acc[p] = 0; m_act[p] = 0; m_hold[p] = 0; m_pend[p] = 0; m_clr[p] = 0; last_out[p] = 0;
    end
    repeat (4) @(negedge clk);
    // R9: outputs while in reset
    chk(!rx_out_valid && !tx_out_valid, "R9", "valid in reset", {rx_out_valid, tx_out_valid}, 0);
    rst = 0;
    @(negedge clk);
    chk(rx_out_i == 0 && rx_out_q == 0 && tx_out_i == 0 && tx_out_q == 0 && !rx_out_valid,
        "R9", "data after reset", longint'(rx_out_i), 0);
    mon_en = 1;

    // R9 / R6 / R3: reset leaves increment 0, so a fresh stream passes through
    send(0, 16'sd1234, -16'sd4321, "R9");
    send(0, -16'sd32768, 16'sd32767, "R6");
    idle(8);

    // table walk: R1, R6, R7 and negative shifts
    for (int k = 0; k < 6; k++) begin
      string r;
      case (k)
        0: r = "R6";
        1: r = "R1";
        2: r = "R1";
        3: r = "R7";
        4: r = "R7";
        default: r = "R1";
      endcase
      set_inc(VEC[k].p, VEC[k].inc);
      clr_phase(VEC[k].p);
      for (int n = 0; n < VEC[k].n; n++) send(VEC[k].p, VEC[k].i, VEC[k].q, r);
      idle(8);
    end

    // R2: latency from a lone sample
    begin
      int lat = 0;
      idle(10);
      send(0, 16'sd500, 16'sd0, "R2");
      for (int n = 1; n <= 12; n++) begin
        idle(1);
        if (rx_out_valid && lat == 0) lat = n;
      end
      chk(lat == 5, "R2", "latency in cycles", lat, 5);
    end

    // R3: idle gaps do not advance the phase
    set_inc(0, 32'h4000_0000);
    clr_phase(0);
    for (int n = 0; n < 4; n++) begin
      send(0, 16'sd7000, -16'sd2000, "R3");
      idle(n + 1);
    end
    idle(8);

    // R4: retune in mid stream, then two writes before the next sample
    set_inc(0, 32'h2000_0000);
    clr_phase(0);
    send(0, 16'sd9000, 16'sd1000, "R4");
    send(0, 16'sd9000, 16'sd1000, "R4");
    idle(1);
    set_inc(0, 32'h4000_0000);
    send(0, 16'sd9000, 16'sd1000, "R4");
    send(0, 16'sd9000, 16'sd1000, "R4");
    idle(1);
    set_inc(0, 32'h1000_0000);
    set_inc(0, 32'hC000_0000);
    send(0, 16'sd9000, 16'sd1000, "R4");
    send(0, 16'sd9000, 16'sd1000, "R4");
    send(0, 16'sd9000, 16'sd1000, "R4");
    idle(8);

    // R5: clear in mid stream
    send(0, 16'sd6000, 16'sd6000, "R5");
    idle(1);
    clr_phase(0);
    send(0, 16'sd6000, 16'sd6000, "R5");
    send(0, 16'sd6000, 16'sd6000, "R5");
    idle(8);

    // R8: both paths at once with different offsets
    set_inc(0, 32'h3333_3333);
    set_inc(1, 32'hCCCC_CCCD);
    clr_phase(0);
    clr_phase(1);
    for (int n = 0; n < 6; n++) send_both(16'sd15000, 16'sd2000, -16'sd8000, 16'sd12000);
    idle(2);
    set_inc(1, 32'h4000_0000);       // retune tx only; rx continues on its own phase
    for (int n = 0; n < 4; n++) send_both(16'sd15000, 16'sd2000, -16'sd8000, 16'sd12000);
    idle(10);

    // drained queues and hold behaviour
    chk(q_exp[0].size() == 0, "R2", "rx results missing", q_exp[0].size(), 0);
    chk(q_exp[1].size() == 0, "R2", "tx results missing", q_exp[1].size(), 0);
    chk(hold_viol == 0, "R10", "data changed while idle", hold_viol, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule